// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Terminal Flags

This block is a synchronous binary counter, four bits wide by default, that steps up or down by one on each rising clock edge. An active-low count enable gates the stepping, and a direction input picks up or down. An active-low preset input forces the count to a parallel data word. The forced value appears at the outputs at once, without waiting for a clock edge, and the counter keeps that value once a rising edge has passed while the preset is held low. Preset takes priority over counting.

Two flags report the count boundary. The terminal flag marks the last state in the present direction: all ones when counting up, all zeros when counting down. The active-low ripple output pulses low at that boundary, but only while counting is enabled and only during the low half of the clock period. A neighbouring stage can use it as a clock.

A build-time option turns the counter into an offset modulo counter. When counting up, the state after all ones is a fixed base value (six by default) instead of zero. The block then cycles through ten states, from 6 to 15.

Top module: `updn_cnt_top`

## Requirements
- R1: While the active-low reset `rst_n` is low, `q` is 0.
- R2: With `ld_n` high, `en_n` low and `down` low (0 = up), each rising edge of `clk` adds one to `q`. In the plain build, 15 is followed by 0.
- R3: With `ld_n` high, `en_n` low and `down` high (1 = down), each rising edge subtracts one from `q`, and 0 is followed by 15. The reload build behaves the same way when counting down.
- R4: With `ld_n` high and `en_n` high, `q` keeps its value across rising edges whatever `down` is.
- R5: While `ld_n` is low, `q` equals `preset` right away, with no clock edge needed. A rising edge while `ld_n` is low stores `preset`, so `q` still holds it after `ld_n` returns high. This happens whatever `en_n` and `down` are.
- R6: `term` is 1 exactly when `q` is 15 and `down` is 0, or when `q` is 0 and `down` is 1. `en_n` has no effect on it.
- R7: `ripple_n` is 0 only when `term` is 1, `en_n` is 0 and `clk` is 0. At all other times it is 1, including the whole high phase of the clock.
- R8: In the reload build (RELOAD_EN=1, RELOAD_VAL=6), counting up from 15 gives 6 instead of 0, so an enabled up count cycles through ten states, 6 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| ld_n | input | 1 | Parallel preset, active low, transparent to `q` |
| preset | input | WIDTH | Value forced into the counter by `ld_n` |
| q | output | WIDTH | Present count, bit 0 is the LSB |
| term | output | 1 | Terminal state for the present direction |
| ripple_n | output | 1 | Active-low cascade pulse during the low clock phase at terminal state |

## Verification
The bench builds two copies side by side, both four bits wide. One is the plain wrapping counter and the other is the reload build with base 6. Both copies get the same stimulus, so a single sweep checks the 15-to-0 wrap and the 15-to-6 reload in the same cycles. Four bits make it cheap to sweep the whole state space: long up and down runs cover every state and both wraps several times. Every preset value is applied with the enable and direction bits set from the value itself, which covers load priority in each control combination. The ripple output is sampled in both clock phases, and once just as the enable falls while the counter sits at zero counting down.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  // Direction encoding seen on the down input.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  // What the next rising edge does to the stored count.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_INC  = 2'd2,
    ACT_DEC  = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/updn_cnt_next.sv
module updn_cnt_next
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RELOAD_EN  = 1'b0,
  parameter int RELOAD_VAL = 6
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             down,
  input  logic             en_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt,
  output cnt_act_e         act,
  output logic             reload_hit
);

  localparam logic [WIDTH-1:0] TOP_Q = {WIDTH{1'b1}};

  // Arithmetic kept in functions so it reads as a plain step rule.
  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    return v + {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [WIDTH-1:0] step_dn(input logic [WIDTH-1:0] v);
    return v - {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  logic [WIDTH-1:0] wrap_q;

  // Priority: preset, then enable, then direction.
  always_comb begin
    if (!ld_n)                act = ACT_LOAD;
    else if (en_n)            act = ACT_HOLD;
    else if (down == DIR_DOWN) act = ACT_DEC;
    else                      act = ACT_INC;
  end

  generate
    if (RELOAD_EN) begin : g_reload
      localparam logic [WIDTH-1:0] BASE_Q = WIDTH'(RELOAD_VAL);
      assign reload_hit = (act == ACT_INC) && (cur == TOP_Q);
      assign wrap_q     = BASE_Q;
    end else begin : g_plain
      assign reload_hit = 1'b0;
      assign wrap_q     = '0;
    end
  endgenerate

  always_comb begin
    unique case (act)
      ACT_LOAD: nxt = preset;
      ACT_INC:  nxt = reload_hit ? wrap_q : step_up(cur);
      ACT_DEC:  nxt = step_dn(cur);
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/updn_cnt_reg.sv
module updn_cnt_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] nxt,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q_reg,
  output logic [WIDTH-1:0] q_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_reg <= '0;
    else        q_reg <= nxt;
  end

  // Preset reaches the outputs without waiting for an edge.
  assign q_out = ld_n ? q_reg : preset;

  // Becomes 1 one edge after reset leaves, so $past below is meaningful.
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R5
  load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(ld_n)) |-> (q_reg == $past(preset)));

  // R5
  load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |-> (q_out == preset));

endmodule

// File: rtl/updn_cnt_flags.sv
module updn_cnt_flags
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] q,
  input  logic             down,
  input  logic             en_n,
  output logic             term,
  output logic             ripple_n
);

  localparam logic [WIDTH-1:0] TOP_Q = {WIDTH{1'b1}};

  logic at_top, at_floor, pulse_ok;

  assign at_top   = (q == TOP_Q);
  assign at_floor = (q == '0);
  assign term     = (down == DIR_DOWN) ? at_floor : at_top;

  // Cascade pulse: only while enabled and in the low clock phase.
  assign pulse_ok = term && !en_n && !clk;
  assign ripple_n = !pulse_ok;

  // R6
  term_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> (at_top || at_floor));

  // R7
  ripple_high_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ripple_n);

  // R7
  ripple_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (en_n || !term) |-> ripple_n);

endmodule

// File: rtl/updn_cnt_top.sv
module updn_cnt_top
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RELOAD_EN  = 1'b0,
  parameter int RELOAD_VAL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             down,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             term,
  output logic             ripple_n
);

  logic [WIDTH-1:0] q_reg;
  logic [WIDTH-1:0] nxt;
  logic             reload_hit;
  cnt_act_e         act;

  updn_cnt_next #(
    .WIDTH      (WIDTH),
    .RELOAD_EN  (RELOAD_EN),
    .RELOAD_VAL (RELOAD_VAL)
  ) u_next (
    .cur        (q_reg),
    .down       (down),
    .en_n       (en_n),
    .ld_n       (ld_n),
    .preset     (preset),
    .nxt        (nxt),
    .act        (act),
    .reload_hit (reload_hit)
  );

  updn_cnt_reg #(
    .WIDTH (WIDTH)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .nxt    (nxt),
    .ld_n   (ld_n),
    .preset (preset),
    .q_reg  (q_reg),
    .q_out  (q)
  );

  updn_cnt_flags #(
    .WIDTH (WIDTH)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .q        (q),
    .down     (down),
    .en_n     (en_n),
    .term     (term),
    .ripple_n (ripple_n)
  );

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ld_n) && !$past(en_n) && !$past(down) && !$past(reload_hit))
      |-> (q_reg == $past(q_reg) + 1'b1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ld_n) && !$past(en_n) && $past(down))
      |-> (q_reg == $past(q_reg) - 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ld_n) && $past(en_n)) |-> $stable(q_reg));

  generate
    if (RELOAD_EN) begin : g_reload_chk
      localparam logic [WIDTH-1:0] BASE_Q = WIDTH'(RELOAD_VAL);
      // R8
      reload_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(reload_hit)) |-> (q_reg == BASE_Q));
    end
  endgenerate

endmodule

// File: tb/sim_updn_cnt_top.sv
`timescale 1ns/1ps
module sim_updn_cnt_top;
  localparam int W  = 4;
  localparam int RV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1;
  logic down = 1'b0;
  logic ld_n = 1'b1;
  logic [W-1:0] preset = '0;

  logic [W-1:0] q0, q1;
  logic tc0, tc1, rp0, rp1;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [W-1:0] m0 = '0;
  logic [W-1:0] m1 = '0;

  always #10 clk = ~clk;

  updn_cnt_top #(.WIDTH(W), .RELOAD_EN(1'b0), .RELOAD_VAL(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .down(down), .ld_n(ld_n),
    .preset(preset), .q(q0), .term(tc0), .ripple_n(rp0));

  updn_cnt_top #(.WIDTH(W), .RELOAD_EN(1'b1), .RELOAD_VAL(RV)) u1 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .down(down), .ld_n(ld_n),
    .preset(preset), .q(q1), .term(tc1), .ripple_n(rp1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected next count from the requirements.
  function automatic logic [W-1:0] model(input logic [W-1:0] v, input bit rl);
    if (!ld_n) return preset;
    if (en_n) return v;
    if (down) return v - 4'd1;
    if (rl && v == 4'd15) return 4'(RV);
    return v + 4'd1;
  endfunction

  function automatic bit term_of(input logic [W-1:0] v);
    return down ? (v == 4'd0) : (v == 4'd15);
  endfunction

  // Called in the low clock phase.
  task automatic check_all(input string t0, input string t1);
    chk({t0, " q plain"}, int'(q0), int'(m0));
    chk({t1, " q reload"}, int'(q1), int'(m1));
    chk("R6 term plain", int'(tc0), int'(term_of(m0)));
    chk("R6 term reload", int'(tc1), int'(term_of(m1)));
    chk("R7 ripple plain", int'(rp0), int'(!(term_of(m0) && !en_n)));
    chk("R7 ripple reload", int'(rp1), int'(!(term_of(m1) && !en_n)));
  endtask

  task automatic step();
    @(posedge clk);
    m0 = model(m0, 1'b0);
    m1 = model(m1, 1'b1);
    #5;
    chk("R7 ripple high phase plain", int'(rp0), 1);
    chk("R7 ripple high phase reload", int'(rp1), 1);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 reset plain", int'(q0), 0);
    chk("R1 reset reload", int'(q1), 0);
    rst_n = 1'b1;

    // R2 / R8: long up run, both wraps several times.
    en_n = 1'b0;
    down = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      check_all("R2", "R8");
    end

    // R3: long down run, wraps from 0 to 15 in both builds.
    down = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step();
      check_all("R3", "R3");
    end

    // R4: hold in both directions.
    en_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      down = i[0];
      step();
      check_all("R4", "R4");
    end

    // R5: every preset value, control bits taken from the value.
    for (int v = 0; v < 16; v++) begin
      preset = 4'(v);
      en_n = v[0];
      down = v[1];
      ld_n = 1'b0;
      #2;
      chk("R5 transparent plain", int'(q0), v);
      chk("R5 transparent reload", int'(q1), v);
      step();
      check_all("R5", "R5");
      ld_n = 1'b1;
      preset = 4'(~v);
      #1;
      chk("R5 stored plain", int'(q0), v);
      chk("R5 stored reload", int'(q1), v);
      step();
      check_all("R5", "R5");
    end

    // R6 / R7: terminal at zero counting down, enable off then on.
    preset = 4'd0;
    down = 1'b1;
    en_n = 1'b1;
    ld_n = 1'b0;
    step();
    ld_n = 1'b1;
    #1;
    check_all("R6", "R6");
    chk("R6 term with enable off", int'(tc0), 1);
    chk("R7 ripple suppressed by enable", int'(rp0), 1);
    en_n = 1'b0;
    #1;
    chk("R7 ripple low at terminal", int'(rp0), 0);
    chk("R7 ripple low at terminal reload", int'(rp1), 0);

    // R8: reload cycle length from 15.
    preset = 4'd15;
    down = 1'b0;
    ld_n = 1'b0;
    step();
    ld_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      check_all("R2", "R8");
    end
    chk("R8 ten states back to 15", int'(q1), 15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule